// File: doc/BRIEF.md
# Quadrature Encoder Timer Counter

A timer counter that turns the two phase signals of an incremental encoder into a position count. It has four counting sources: internal clock ticks with a software-chosen direction, edges of phase A with phase B giving the direction, edges of phase B with phase A giving the direction, and full quadrature, which decodes both phases into four counts per encoder cycle. The count wraps against a programmable preset. Reaching the preset while counting up, or reaching zero while counting down, produces a one-cycle update pulse.

Software drives the block through a small memory-mapped register port. Through this port it enables counting, picks the counting source, reads and overwrites the counter, and programs the preset. The preset can be buffered so that a new value takes effect only at the next wrap. A separate trigger output carries one of several internal events, chosen by a select field. Another counter block can chain from this output.

Top module: `qenc_timer`

## Requirements
- R1: After reset, every register reads 0, and `upd_evt` and `trig_out` are low.
- R2: Register map. Register 0x00 holds enable in bit 0, direction in bit 4 (0 = up, 1 = down) and preset buffering in bit 7. Register 0x04 holds the trigger select in bits [6:4]. Register 0x08 holds the counting source in bits [2:0]. Writing 1 to bit 0 of register 0x14 issues a software strobe. Register 0x24 is the counter: it is readable, and a write replaces its value, keeping the low CNT_W bits. Register 0x2C is the preset: a read returns the last value written. A read request returns its data on `bus_rdata` one cycle later, with `bus_rvalid` high.
- R3: While counting up, a step taken with the counter at or above the active preset sets the counter to 0 and raises `upd_evt` for exactly that cycle.
- R4: While counting down, a step taken with the counter at 0 loads the active preset and raises `upd_evt` for that cycle.
- R5: With source 0, the counter steps once per clock in the direction of bit 4. Whatever the source, nothing counts while enable is 0.
- R6: With source 1, each rising or falling edge of `enc_a` is one step: up if `enc_b` is low, down if it is high. Changes of `enc_b` alone do not count.
- R7: With source 2, each edge of `enc_b` is one step: up if `enc_a` is low, down if it is high. Changes of `enc_a` alone do not count.
- R8: With source 3, the pair (A,B) stepping 00→10→11→01→00 counts up one per state change, and the reverse order counts down. A change of both phases at once does not count.
- R9: With sources 1 to 3, writes to the direction bit are ignored. Bit 4 then reads the direction of the last counted step.
- R10: With buffering on, a preset write changes only the buffered value, which moves to the active preset at the next update. With buffering off, the write takes effect at once.
- R11: `trig_out` is a registered copy, one cycle late, of the source picked by the select field. The choices are: 0 the software strobe, 1 the enable level, 2 the update pulse, 3 a pulse on a rising edge of `cmp_ref[0]`, 4 to 7 the levels `cmp_ref[0]` to `cmp_ref[3]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| bus_rvalid | output | 1 | Read data valid |
| enc_a | input | 1 | Encoder phase A, asynchronous |
| enc_b | input | 1 | Encoder phase B, asynchronous |
| cmp_ref | input | 4 | Compare reference levels |
| upd_evt | output | 1 | One-cycle update (wrap) pulse |
| trig_out | output | 1 | Selected trigger source |

## Verification
The count is driven three ways. Free-running ticks in both directions measure the number of cycles between update pulses, which tells a preset used at once from a buffered one. A forward Gray sequence followed by a reverse one separates the two quadrature directions. A jump of both phases at once shows that an illegal move is rejected. In the two single-edge modes, the bench toggles the counted phase at both levels of the other phase, and also toggles the other phase alone. This shows that both edges count, that the level steers the direction, and that the second phase never counts. Trigger selection is checked by the one-cycle lag and the pulse width of each source.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

    localparam logic [7:0] OFS_CTRL  = 8'h00;
    localparam logic [7:0] OFS_MSEL  = 8'h04;
    localparam logic [7:0] OFS_SMODE = 8'h08;
    localparam logic [7:0] OFS_EVT   = 8'h14;
    localparam logic [7:0] OFS_CNT   = 8'h24;
    localparam logic [7:0] OFS_PRE   = 8'h2C;

    localparam int BIT_EN   = 0;
    localparam int BIT_DIR  = 4;
    localparam int BIT_PRE  = 7;
    localparam int MSEL_LSB = 4;
    localparam int FIELD_W  = 3;

    typedef enum logic [2:0] {
        SM_TICK   = 3'd0,
        SM_EDGE_A = 3'd1,
        SM_EDGE_B = 3'd2,
        SM_QUAD   = 3'd3,
        SM_RSV4   = 3'd4,
        SM_RSV5   = 3'd5,
        SM_RSV6   = 3'd6,
        SM_RSV7   = 3'd7
    } smode_e;

    typedef enum logic [2:0] {
        MM_SWGEN  = 3'd0,
        MM_ENABLE = 3'd1,
        MM_UPDATE = 3'd2,
        MM_CMP1P  = 3'd3,
        MM_REF1   = 3'd4,
        MM_REF2   = 3'd5,
        MM_REF3   = 3'd6,
        MM_REF4   = 3'd7
    } msel_e;

    typedef struct packed {
        logic lvl;
        logic prev;
        logic chg;
    } pin_t;

    // Gray decode: down when current A equals previous B
    function automatic logic quad_down(input logic a_now, input logic b_before);
        return ~(a_now ^ b_before);
    endfunction

endpackage

// File: rtl/qenc_insync.sv
module qenc_insync #(
    parameter int N      = 2,
    parameter int STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [N-1:0]             pin_i,
    output qenc_pkg::pin_t [N-1:0]   pin_o
);
    for (genvar g = 0; g < N; g++) begin : g_pin
        logic [STAGES-1:0] chain_q;
        logic              prev_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                chain_q <= '0;
                prev_q  <= 1'b0;
            end else begin
                chain_q <= {chain_q[STAGES-2:0], pin_i[g]};
                prev_q  <= chain_q[STAGES-1];
            end
        end

        assign pin_o[g].lvl  = chain_q[STAGES-1];
        assign pin_o[g].prev = prev_q;
        assign pin_o[g].chg  = chain_q[STAGES-1] ^ prev_q;
    end
endmodule

// File: rtl/qenc_decode.sv
module qenc_decode
    import qenc_pkg::*;
(
    input  smode_e mode_i,
    input  logic   sw_dn_i,
    input  logic   a_lvl_i,
    input  logic   a_chg_i,
    input  logic   b_lvl_i,
    input  logic   b_chg_i,
    input  logic   b_prev_i,
    output logic   step_o,
    output logic   dn_o
);
    always_comb begin
        step_o = 1'b0;
        dn_o   = 1'b0;
        unique case (mode_i)
            SM_TICK: begin
                step_o = 1'b1;
                dn_o   = sw_dn_i;
            end
            SM_EDGE_A: begin
                step_o = a_chg_i;
                dn_o   = b_lvl_i;
            end
            SM_EDGE_B: begin
                step_o = b_chg_i;
                dn_o   = a_lvl_i;
            end
            SM_QUAD: begin
                step_o = a_chg_i ^ b_chg_i;
                dn_o   = quad_down(a_lvl_i, b_prev_i);
            end
            default: begin
                step_o = 1'b0;
                dn_o   = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/qenc_count.sv
module qenc_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic             step_i,
    input  logic             dn_i,
    input  logic             pre_en_i,
    input  logic             cnt_we_i,
    input  logic             arr_we_i,
    input  logic [CNT_W-1:0] wd_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] arr_sh_o,
    output logic             upd_o
);
    logic [CNT_W-1:0] cnt_q, arr_act_q, arr_sh_q, cnt_nx;
    logic             upd_q, wrap, advance;

    assign advance = en_i && step_i && !cnt_we_i;

    always_comb begin
        wrap   = 1'b0;
        cnt_nx = cnt_q;
        if (dn_i) begin
            if (cnt_q == '0) begin
                cnt_nx = arr_act_q;
                wrap   = 1'b1;
            end else begin
                cnt_nx = cnt_q - 1'b1;
            end
        end else begin
            if (cnt_q >= arr_act_q) begin
                cnt_nx = '0;
                wrap   = 1'b1;
            end else begin
                cnt_nx = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            arr_act_q <= '0;
            arr_sh_q  <= '0;
            upd_q     <= 1'b0;
        end else begin
            upd_q <= advance && wrap;
            if (cnt_we_i) begin
                cnt_q <= wd_i;
            end else if (advance) begin
                cnt_q <= cnt_nx;
            end
            if (arr_we_i) begin
                arr_sh_q <= wd_i;
            end
            if (arr_we_i && !pre_en_i) begin
                arr_act_q <= wd_i;
            end else if (advance && wrap) begin
                arr_act_q <= arr_sh_q;
            end
        end
    end

    assign cnt_o    = cnt_q;
    assign arr_sh_o = arr_sh_q;
    assign upd_o    = upd_q;

    AST_WRAP_VALUE: assert property (@(posedge clk) disable iff (rst)
        upd_q |-> ((cnt_q == '0) || (cnt_q == $past(arr_act_q)))) else $error("wrap value"); // R3
    AST_HOLD_OFF: assert property (@(posedge clk) disable iff (rst)
        (!$past(en_i) && !$past(cnt_we_i)) |-> $stable(cnt_q)) else $error("count while off"); // R5
    AST_PRESET_SHADOW: assert property (@(posedge clk) disable iff (rst)
        !$stable(arr_act_q) |-> (upd_q || !$past(pre_en_i))) else $error("preset moved early"); // R10
endmodule

// File: rtl/qenc_trgsel.sv
module qenc_trgsel
    import qenc_pkg::*;
#(
    parameter int NUM_REF = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  msel_e              sel_i,
    input  logic               swgen_i,
    input  logic               en_i,
    input  logic               upd_i,
    input  logic [NUM_REF-1:0] ref_i,
    output logic               trg_o
);
    logic ref0_q, src, trg_q;

    always_comb begin
        src = 1'b0;
        unique case (sel_i)
            MM_SWGEN:  src = swgen_i;
            MM_ENABLE: src = en_i;
            MM_UPDATE: src = upd_i;
            MM_CMP1P:  src = ref_i[0] & ~ref0_q;
            default: begin
                for (int k = 0; k < NUM_REF; k++) begin
                    if (int'(sel_i) == int'(MM_REF1) + k) src = ref_i[k];
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ref0_q <= 1'b0;
            trg_q  <= 1'b0;
        end else begin
            ref0_q <= ref_i[0];
            trg_q  <= src;
        end
    end

    assign trg_o = trg_q;

    AST_TRG_UPDATE: assert property (@(posedge clk) disable iff (rst)
        (sel_i == MM_UPDATE && upd_i) |=> trg_q) else $error("update not forwarded"); // R11
endmodule

// File: rtl/qenc_timer.sv
module qenc_timer
    import qenc_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 8,
    parameter int NUM_REF     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_en,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               bus_rvalid,
    input  logic               enc_a,
    input  logic               enc_b,
    input  logic [NUM_REF-1:0] cmp_ref,
    output logic               upd_evt,
    output logic               trig_out
);
    localparam int PIN_A = 0;
    localparam int PIN_B = 1;

    logic   en_q, pre_en_q, sw_dir_q, dir_dec_q, swgen_q;
    smode_e smode_q;
    msel_e  msel_q;
    logic   wr, rd, wr_ctrl, wr_cnt, wr_pre;
    logic   step, dn, dir_rd;
    logic [CNT_W-1:0] cnt, arr_sh;
    logic [DATA_W-1:0] rd_mux, rdata_q;
    logic   rvalid_q;
    pin_t [1:0] pins;
    logic   unused_wd;

    assign unused_wd = ^bus_wdata;
    assign wr      = bus_en && bus_we;
    assign rd      = bus_en && !bus_we;
    assign wr_ctrl = wr && (bus_addr == ADDR_W'(OFS_CTRL));
    assign wr_cnt  = wr && (bus_addr == ADDR_W'(OFS_CNT));
    assign wr_pre  = wr && (bus_addr == ADDR_W'(OFS_PRE));

    qenc_insync #(.N(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .pin_i ({enc_b, enc_a}),
        .pin_o (pins)
    );

    qenc_decode u_dec (
        .mode_i   (smode_q),
        .sw_dn_i  (sw_dir_q),
        .a_lvl_i  (pins[PIN_A].lvl),
        .a_chg_i  (pins[PIN_A].chg),
        .b_lvl_i  (pins[PIN_B].lvl),
        .b_chg_i  (pins[PIN_B].chg),
        .b_prev_i (pins[PIN_B].prev),
        .step_o   (step),
        .dn_o     (dn)
    );

    qenc_count #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .en_i     (en_q),
        .step_i   (step),
        .dn_i     (dn),
        .pre_en_i (pre_en_q),
        .cnt_we_i (wr_cnt),
        .arr_we_i (wr_pre),
        .wd_i     (bus_wdata[CNT_W-1:0]),
        .cnt_o    (cnt),
        .arr_sh_o (arr_sh),
        .upd_o    (upd_evt)
    );

    qenc_trgsel #(.NUM_REF(NUM_REF)) u_trg (
        .clk     (clk),
        .rst     (rst),
        .sel_i   (msel_q),
        .swgen_i (swgen_q),
        .en_i    (en_q),
        .upd_i   (upd_evt),
        .ref_i   (cmp_ref),
        .trg_o   (trig_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q      <= 1'b0;
            pre_en_q  <= 1'b0;
            sw_dir_q  <= 1'b0;
            dir_dec_q <= 1'b0;
            swgen_q   <= 1'b0;
            smode_q   <= SM_TICK;
            msel_q    <= MM_SWGEN;
        end else begin
            swgen_q <= wr && (bus_addr == ADDR_W'(OFS_EVT)) && bus_wdata[0];
            if (wr_ctrl) begin
                en_q     <= bus_wdata[BIT_EN];
                pre_en_q <= bus_wdata[BIT_PRE];
                if (smode_q == SM_TICK) sw_dir_q <= bus_wdata[BIT_DIR];
            end
            if (wr && (bus_addr == ADDR_W'(OFS_MSEL)))
                msel_q <= msel_e'(bus_wdata[MSEL_LSB +: FIELD_W]);
            if (wr && (bus_addr == ADDR_W'(OFS_SMODE)))
                smode_q <= smode_e'(bus_wdata[FIELD_W-1:0]);
            if (en_q && step && (smode_q != SM_TICK))
                dir_dec_q <= dn;
        end
    end

    assign dir_rd = (smode_q == SM_TICK) ? sw_dir_q : dir_dec_q;

    always_comb begin
        rd_mux = '0;
        case (bus_addr)
            ADDR_W'(OFS_CTRL): begin
                rd_mux[BIT_EN]  = en_q;
                rd_mux[BIT_DIR] = dir_rd;
                rd_mux[BIT_PRE] = pre_en_q;
            end
            ADDR_W'(OFS_MSEL):  rd_mux[MSEL_LSB +: FIELD_W] = msel_q;
            ADDR_W'(OFS_SMODE): rd_mux[FIELD_W-1:0] = smode_q;
            ADDR_W'(OFS_CNT):   rd_mux[CNT_W-1:0] = cnt;
            ADDR_W'(OFS_PRE):   rd_mux[CNT_W-1:0] = arr_sh;
            default:            rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= rd;
            rdata_q  <= rd ? rd_mux : '0;
        end
    end

    assign bus_rdata  = rdata_q;
    assign bus_rvalid = rvalid_q;

    AST_DIR_READONLY: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && smode_q != SM_TICK) |=> $stable(sw_dir_q)) else $error("dir written in encoder mode"); // R9
    AST_NO_DOUBLE_STEP: assert property (@(posedge clk) disable iff (rst)
        (smode_q == SM_QUAD && pins[PIN_A].chg && pins[PIN_B].chg) |-> !step) else $error("illegal step"); // R8
endmodule

// File: tb/tb_qenc_timer.sv
module tb_qenc_timer;
    timeunit 1ns;
    timeprecision 100ps;

    localparam logic [7:0] A_CTRL = 8'h00, A_MSEL = 8'h04, A_SMODE = 8'h08,
                           A_EVT = 8'h14, A_CNT = 8'h24, A_PRE = 8'h2C;

    logic        clk = 1'b0, rst = 1'b1;
    logic        bus_en = 1'b0, bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        bus_rvalid, enc_a = 1'b0, enc_b = 1'b0, upd_evt, trig_out;
    logic [3:0]  cmp_ref = '0;

    always #2.5 clk = ~clk;

    qenc_timer dut (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .enc_a(enc_a), .enc_b(enc_b), .cmp_ref(cmp_ref), .upd_evt(upd_evt), .trig_out(trig_out)
    );

    int n_chk = 0, n_err = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // monitor: pops expected read data as the design returns it
    initial begin
        forever begin
            @(negedge clk);
            if (bus_rvalid) begin
                if (exp_q.size() == 0) chk("R2 unexpected read data", 32'h1, 32'h0);
                else chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd_exp(input logic [7:0] a, input logic [31:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic set_ab(input logic a, input logic b);
        enc_a = a; enc_b = b;
        idle(4);
    endtask

    task automatic wait_upd(output int n);
        n = 0;
        while (!upd_evt) begin @(negedge clk); n++; end
    endtask

    task automatic next_upd(output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!upd_evt);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired (run hung) actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int n;
        idle(4);
        rst = 1'b0;
        idle(1);

        // R1 reset state
        chk("R1 upd_evt low", {31'b0, upd_evt}, 32'h0);
        chk("R1 trig_out low", {31'b0, trig_out}, 32'h0);
        rd_exp(A_CTRL, 32'h0, "R1 ctrl");
        rd_exp(A_MSEL, 32'h0, "R1 msel");
        rd_exp(A_SMODE, 32'h0, "R1 smode");
        rd_exp(A_CNT, 32'h0, "R1 counter");
        rd_exp(A_PRE, 32'h0, "R1 preset");

        // R2 register access
        wr(A_CNT, 32'h0001_2345);
        rd_exp(A_CNT, 32'h2345, "R2 counter write truncated");
        wr(A_PRE, 32'h55);
        rd_exp(A_PRE, 32'h55, "R2 preset readback");
        wr(A_MSEL, 32'hFF);
        rd_exp(A_MSEL, 32'h70, "R2 msel field");
        wr(A_MSEL, 32'h0);
        wr(A_SMODE, 32'h0B);
        rd_exp(A_SMODE, 32'h3, "R2 smode field");
        wr(A_SMODE, 32'h0);

        // R3 / R5 tick mode up
        wr(A_PRE, 32'd5);
        wr(A_CNT, 32'd0);
        wr(A_CTRL, 32'h01);
        wait_upd(n);
        chk("R3 cycles to up wrap", n, 32'd6);
        wr(A_CTRL, 32'h00);
        rd_exp(A_CNT, 32'd1, "R3 count after wrap");
        idle(5);
        rd_exp(A_CNT, 32'd1, "R5 held while disabled");

        // R4 tick mode down
        wr(A_CNT, 32'd2);
        wr(A_CTRL, 32'h11);
        wait_upd(n);
        chk("R4 cycles to down wrap", n, 32'd3);
        wr(A_CTRL, 32'h10);
        rd_exp(A_CNT, 32'd4, "R4 reload from preset");
        rd_exp(A_CTRL, 32'h10, "R9 dir writable in tick mode");

        // R11 trigger select
        wr(A_MSEL, 32'h10);
        wr(A_CTRL, 32'h01);
        idle(2);
        chk("R11 enable level trigger", {31'b0, trig_out}, 32'h1);
        wr(A_CTRL, 32'h00);
        idle(2);
        chk("R11 enable level low", {31'b0, trig_out}, 32'h0);
        wr(A_MSEL, 32'h20);
        wr(A_CNT, 32'd0);
        wr(A_CTRL, 32'h01);
        wait_upd(n);
        @(negedge clk);
        chk("R11 update forwarded", {31'b0, trig_out}, 32'h1);
        @(negedge clk);
        chk("R11 update one cycle", {31'b0, trig_out}, 32'h0);
        wr(A_CTRL, 32'h00);
        wr(A_MSEL, 32'h00);
        wr(A_EVT, 32'h1);
        @(negedge clk);
        chk("R11 software strobe", {31'b0, trig_out}, 32'h1);
        @(negedge clk);
        chk("R11 strobe one cycle", {31'b0, trig_out}, 32'h0);
        wr(A_MSEL, 32'h30);
        cmp_ref = 4'b0001;
        @(negedge clk);
        chk("R11 compare pulse", {31'b0, trig_out}, 32'h1);
        @(negedge clk);
        chk("R11 compare pulse ends", {31'b0, trig_out}, 32'h0);
        cmp_ref = 4'b0100;
        wr(A_MSEL, 32'h60);
        idle(2);
        chk("R11 ref3 level high", {31'b0, trig_out}, 32'h1);
        cmp_ref = 4'b1011;
        idle(2);
        chk("R11 ref3 level low", {31'b0, trig_out}, 32'h0);
        cmp_ref = 4'b0000;
        wr(A_MSEL, 32'h00);

        // R10 preset buffering
        wr(A_CTRL, 32'h80);
        wr(A_PRE, 32'd9);
        rd_exp(A_PRE, 32'd9, "R10 buffered preset reads back");
        wr(A_CNT, 32'd0);
        wr(A_CTRL, 32'h81);
        wait_upd(n);
        chk("R10 old preset until update", n, 32'd6);
        next_upd(n);
        chk("R10 new preset after update", n, 32'd10);
        wr(A_CTRL, 32'h80);
        wr(A_CTRL, 32'h00);
        wr(A_PRE, 32'd3);
        wr(A_CNT, 32'd0);
        wr(A_CTRL, 32'h01);
        wait_upd(n);
        chk("R10 immediate preset", n, 32'd4);
        wr(A_CTRL, 32'h00);

        // R8 / R9 quadrature
        wr(A_SMODE, 32'd3);
        wr(A_PRE, 32'd100);
        wr(A_CNT, 32'd10);
        wr(A_CTRL, 32'h01);
        set_ab(1, 0); set_ab(1, 1); set_ab(0, 1); set_ab(0, 0);
        rd_exp(A_CNT, 32'd14, "R8 four counts per cycle up");
        rd_exp(A_CTRL, 32'h01, "R9 decoded up");
        set_ab(0, 1); set_ab(1, 1);
        rd_exp(A_CNT, 32'd12, "R8 B leading counts down");
        rd_exp(A_CTRL, 32'h11, "R9 decoded down");
        wr(A_CTRL, 32'h01);
        rd_exp(A_CTRL, 32'h11, "R9 dir write ignored");
        set_ab(0, 0);
        rd_exp(A_CNT, 32'd12, "R8 double change ignored");
        wr(A_PRE, 32'd3);
        wr(A_CNT, 32'd3);
        set_ab(1, 0);
        rd_exp(A_CNT, 32'd0, "R3 quadrature up wrap");
        set_ab(0, 0);
        rd_exp(A_CNT, 32'd3, "R4 quadrature down wrap");

        // R6 edges of A
        wr(A_SMODE, 32'd1);
        wr(A_PRE, 32'd1000);
        wr(A_CNT, 32'd50);
        set_ab(1, 0); set_ab(0, 0);
        rd_exp(A_CNT, 32'd52, "R6 both A edges up");
        set_ab(0, 1);
        rd_exp(A_CNT, 32'd52, "R6 B alone no count");
        set_ab(1, 1); set_ab(0, 1);
        rd_exp(A_CNT, 32'd50, "R6 B high counts down");
        rd_exp(A_CTRL, 32'h11, "R9 mode1 direction");
        set_ab(0, 0);

        // R7 edges of B
        wr(A_SMODE, 32'd2);
        wr(A_CNT, 32'd50);
        set_ab(0, 1); set_ab(0, 0);
        rd_exp(A_CNT, 32'd52, "R7 both B edges up");
        rd_exp(A_CTRL, 32'h01, "R9 mode2 direction");
        set_ab(1, 0);
        rd_exp(A_CNT, 32'd52, "R7 A alone no count");
        set_ab(1, 1); set_ab(1, 0);
        rd_exp(A_CNT, 32'd50, "R7 A high counts down");
        wr(A_CTRL, 32'h00);
        set_ab(1, 1); set_ab(1, 0);
        rd_exp(A_CNT, 32'd50, "R5 encoder held while disabled");

        idle(3);
        if (exp_q.size() != 0) chk("R2 reads outstanding", exp_q.size(), 32'd0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule